// File: doc/BRIEF.md
# Interrupt Priority and Service Controller

This block keeps track of which of 256 interrupt vectors are requested and which are in service. It chooses the next vector to hand to a processor core. The choice uses 4-bit priority classes: a vector's class is its upper four bits. A requested vector is offered only when its class is strictly above the class of a processor-priority value. That value is derived from a programmable task priority and from the most recently accepted, still-unfinished vector.

A source raises a request by pulsing `set_valid` with a vector number. The core takes the offered vector by pulsing `accept`, which moves the vector from the request bitmap to the in-service bitmap and pushes it onto a nesting stack. The core ends service by pulsing `eoi`, which retires the highest in-service vector and pops the stack. Vectors 0 to 31 can be recorded as requests but are never offered. Both bitmaps, the task priority and the processor priority can be read back one word at a time.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, both bitmaps, the task priority and the processor priority read zero, `pend_valid` is low and `proto_err` is low.
- R2: A `set_valid` pulse sets the request bit of `set_vector` at the next clock edge. Setting a bit that is already set changes nothing. A request for a vector below 32 is stored but is never offered.
- R3: `pend_vector` is the highest requested vector at or above 32. `pend_valid` is high only when that vector's class (bits 7:4) is strictly greater than the processor-priority class. Both reflect any update from the cycle after the clock edge that made it.
- R4: `accept` while `pend_valid` is high clears that vector's request bit, sets its in-service bit and pushes it on the nesting stack. `accept` while `pend_valid` is low has no effect.
- R5: The processor priority equals the task priority when the task-priority class is at least the class of the stack top. Otherwise it equals the stack-top vector with bits 3:0 cleared. An empty stack counts as vector 0.
- R6: A `tpr_we` pulse loads bits 7:0 of `tpr_wdata` into the task priority. The upper bits are discarded.
- R7: An `eoi` pulse with at least one vector in service clears the highest set in-service bit and pops the stack.
- R8: An `eoi` pulse with nothing in service changes no state, and `proto_err` is high for exactly the following cycle.
- R9: Stacked vectors have strictly increasing classes from bottom to top. The highest set in-service bit always equals the stack top.
- R10: `rd_data` is combinational from `rd_sel`. With bits 4:3 = 0, it returns request word `rd_sel[2:0]`, covering vectors 32*w to 32*w+31, with bit 0 holding the lowest of them. With bits 4:3 = 1, it returns the in-service word in the same layout. With bits 4:3 = 2, it returns the task priority, zero-extended. With bits 4:3 = 3, it returns the processor priority, zero-extended.
- R11: When `eoi` and `accept` arrive in the same cycle, the end-of-interrupt is processed and the accept is ignored. When `set_valid` and an accept arrive in the same cycle, the new request bit is applied after the accept clears its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Request strobe for `set_vector` |
| set_vector | input | 8 | Vector to request |
| accept | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End of interrupt for the current service level |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data (bits 7:0 used) |
| rd_sel | input | 5 | Read-back select: kind in 4:3, word in 2:0 |
| pend_valid | output | 1 | A vector is offered to the core |
| pend_vector | output | 8 | Offered vector |
| proto_err | output | 1 | End of interrupt arrived with nothing in service |
| rd_data | output | 32 | Read-back data |

## Verification
The assertions take for granted that every strobe and `set_vector` are driven to known levels on every cycle. They also assume that no internal path other than this block's own accept and end-of-interrupt logic pushes or pops the nesting stack. The stimulus drives all inputs away from the clock edge and returns the strobes to zero after each cycle. Random traffic deliberately issues end-of-interrupt pulses with an empty stack and accept pulses with nothing offered. The block itself must filter these, so the stack-level checks on push and pop hold for any input sequence.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLS_W   = 4;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  typedef enum logic [1:0] {
    RD_REQ = 2'd0,
    RD_SVC = 2'd1,
    RD_TPR = 2'd2,
    RD_PPR = 2'd3
  } rd_kind_e;

  // Priority class: upper bits of a vector or priority value.
  function automatic cls_t prio_class(input vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // Processor priority from task priority and the top in-service vector.
  function automatic vec_t calc_ppr(input vec_t tpr, input vec_t top);
    if (prio_class(tpr) >= prio_class(top)) return tpr;
    return {prio_class(top), {(VEC_W-CLS_W){1'b0}}};
  endfunction
endpackage

// File: rtl/irq_find_msb.sv
`timescale 1ns/1ps
module irq_find_msb #(
  parameter  int W  = 256,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_isr_stack.sv
`timescale 1ns/1ps
module irq_isr_stack
  import irq_prio_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  vec_t          push_vec,
  input  logic          pop,
  output vec_t          top_vec,
  output logic [PW-1:0] depth
);
  // Entry 0 is never written and stands for "nothing in service".
  vec_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[depth + 1'b1] <= push_vec;
      depth             <= depth + 1'b1;
    end else if (pop) begin
      depth <= depth - 1'b1;
    end
  end

  assign top_vec = mem[depth];

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (depth != PW'(DEPTH-1)));
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (depth != '0));
  // R9
  class_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (prio_class(push_vec) > prio_class(top_vec)));
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter  int WORD_W     = 32,
  parameter  int RSVD_WORDS = 1,
  parameter  int STK_DEPTH  = 16,
  localparam int NUM_WORDS  = NUM_VEC / WORD_W,
  localparam int WSEL_W     = $clog2(NUM_WORDS),
  localparam int SEL_W      = 2 + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [VEC_W-1:0]  set_vector,
  input  logic              accept,
  input  logic              eoi,
  input  logic              tpr_we,
  input  logic [WORD_W-1:0] tpr_wdata,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic              pend_valid,
  output logic [VEC_W-1:0]  pend_vector,
  output logic              proto_err,
  output logic [WORD_W-1:0] rd_data
);
  localparam int PW        = $clog2(STK_DEPTH);
  localparam int RSVD_BITS = RSVD_WORDS * WORD_W;
  localparam logic [NUM_VEC-1:0] LIVE_MASK =
    ~((NUM_VEC'(1) << RSVD_BITS) - NUM_VEC'(1));

  logic [NUM_VEC-1:0] irr_q, isr_q;
  vec_t               tpr_q;
  logic               err_q;

  vec_t               stk_top;
  logic [PW-1:0]      stk_depth;
  vec_t               ppr;

  logic               req_found, svc_found;
  vec_t               req_idx, svc_idx;

  logic               eoi_fire, eoi_bad, acc_fire;
  logic [NUM_VEC-1:0] acc_mask, set_mask, eoi_mask;

  // Highest live request and highest in-service vector.
  irq_find_msb #(.W(NUM_VEC)) u_req_msb (
    .bits (irr_q & LIVE_MASK),
    .found(req_found),
    .idx  (req_idx)
  );

  irq_find_msb #(.W(NUM_VEC)) u_svc_msb (
    .bits (isr_q & LIVE_MASK),
    .found(svc_found),
    .idx  (svc_idx)
  );

  assign ppr         = calc_ppr(tpr_q, stk_top);
  assign pend_vector = req_idx;
  assign pend_valid  = req_found && (prio_class(req_idx) > prio_class(ppr));

  // Event qualification: EOI wins over accept in the same cycle.
  assign eoi_fire = eoi && (stk_depth != '0);
  assign eoi_bad  = eoi && (stk_depth == '0);
  assign acc_fire = accept && pend_valid && !eoi;

  assign acc_mask = acc_fire  ? (NUM_VEC'(1) << pend_vector) : '0;
  assign set_mask = set_valid ? (NUM_VEC'(1) << set_vector)  : '0;
  assign eoi_mask = eoi_fire  ? (NUM_VEC'(1) << svc_idx)     : '0;

  irq_isr_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (acc_fire),
    .push_vec(pend_vector),
    .pop     (eoi_fire),
    .top_vec (stk_top),
    .depth   (stk_depth)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tpr_q <= '0;
      err_q <= 1'b0;
    end else begin
      irr_q <= (irr_q & ~acc_mask) | set_mask;
      isr_q <= (isr_q | acc_mask) & ~eoi_mask;
      if (tpr_we) tpr_q <= tpr_wdata[VEC_W-1:0];
      err_q <= eoi_bad;
    end
  end

  assign proto_err = err_q;

  // Read-back mux.
  logic [WSEL_W-1:0] rd_word;
  rd_kind_e          rd_kind;
  assign rd_word = rd_sel[WSEL_W-1:0];
  assign rd_kind = rd_kind_e'(rd_sel[SEL_W-1 -: 2]);

  always_comb begin
    case (rd_kind)
      RD_REQ:  rd_data = irr_q[rd_word*WORD_W +: WORD_W];
      RD_SVC:  rd_data = isr_q[rd_word*WORD_W +: WORD_W];
      RD_TPR:  rd_data = WORD_W'(tpr_q);
      default: rd_data = WORD_W'(ppr);
    endcase
  end

  // R9
  svc_top_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_depth != '0) |-> (svc_found && (svc_idx == stk_top)));
  // R9
  svc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_depth == '0) |-> !svc_found);
  // R4
  accept_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !(set_valid && set_vector == pend_vector))
      |=> (!irr_q[$past(pend_vector)] && isr_q[$past(pend_vector)]));
  // R7
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> ((stk_depth == $past(stk_depth) - 1'b1) && !isr_q[$past(svc_idx)]));
  // R6
  tpr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_we |=> (tpr_q == $past(tpr_wdata[VEC_W-1:0])));
  // R3
  pend_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (pend_vector >= VEC_W'(RSVD_BITS)));
  // R8
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bad |=> ($stable(isr_q) && proto_err));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        set_valid, accept, eoi, tpr_we;
  logic [7:0]  set_vector;
  logic [31:0] tpr_wdata;
  logic [4:0]  rd_sel;
  logic        pend_valid, proto_err;
  logic [7:0]  pend_vector;
  logic [31:0] rd_data;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
    .accept(accept), .eoi(eoi), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
    .rd_sel(rd_sel), .pend_valid(pend_valid), .pend_vector(pend_vector),
    .proto_err(proto_err), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model state.
  logic [255:0] m_irr, m_isr;
  logic [7:0]   m_tpr;
  logic [7:0]   m_stk [16];
  int           m_dep;
  logic         m_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ppr();
    logic [7:0] top = m_stk[m_dep];
    if ((m_tpr >> 4) >= (top >> 4)) return m_tpr;
    return top & 8'hF0;
  endfunction

  function automatic void exp_pend(output logic v, output logic [7:0] vec);
    logic hit = 1'b0;
    logic [7:0] p = exp_ppr();
    vec = 8'h0;
    for (int w = 7; w >= 1; w--)
      for (int b = 31; b >= 0; b--)
        if (!hit && m_irr[w*32+b]) begin hit = 1'b1; vec = 8'(w*32+b); end
    v = hit && ((vec >> 4) > (p >> 4));
  endfunction

  function automatic logic [31:0] exp_rd(input int sel);
    case (sel >> 3)
      0:       return m_irr[(sel & 7)*32 +: 32];
      1:       return m_isr[(sel & 7)*32 +: 32];
      2:       return {24'h0, m_tpr};
      default: return {24'h0, exp_ppr()};
    endcase
  endfunction

  task automatic expect_rd(input string req, input int sel, input logic [31:0] exp);
    rd_sel = 5'(sel);
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic compare_all();
    logic v;
    logic [7:0] vv;
    int sel;
    string tag;
    exp_pend(v, vv);
    chk("R3 pend_valid", 32'(pend_valid), 32'(v));
    if (v) chk("R3 pend_vector", 32'(pend_vector), 32'(vv));
    chk("R8 proto_err", 32'(proto_err), 32'(m_err));
    sel = $urandom_range(0, 31);
    case (sel >> 3)
      0: tag = "R2 R10 request word";
      1: tag = "R4 R10 service word";
      2: tag = "R6 R10 task priority";
      default: tag = "R5 R10 processor priority";
    endcase
    expect_rd(tag, sel, exp_rd(sel));
  endtask

  task automatic cycle(input logic sv, input logic [7:0] vec, input logic acc,
                       input logic e, input logic tw, input logic [31:0] td);
    logic pv;
    logic [7:0] pvec;
    logic hit;
    set_valid = sv; set_vector = vec; accept = acc; eoi = e;
    tpr_we = tw; tpr_wdata = td;
    exp_pend(pv, pvec);
    @(posedge clk);
    m_err = e && (m_dep == 0);
    if (e && m_dep != 0) begin
      hit = 1'b0;
      for (int i = 255; i >= 32; i--)
        if (!hit && m_isr[i]) begin hit = 1'b1; m_isr[i] = 1'b0; end
      m_dep--;
    end else if (!e && acc && pv) begin
      m_irr[pvec] = 1'b0;
      m_isr[pvec] = 1'b1;
      m_dep++;
      m_stk[m_dep] = pvec;
    end
    if (sv) m_irr[vec] = 1'b1;
    if (tw) m_tpr = td[7:0];
    @(negedge clk);
    set_valid = 1'b0; accept = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; set_valid = 0; set_vector = 0; accept = 0; eoi = 0;
    tpr_we = 0; tpr_wdata = 0; rd_sel = 0;
    m_irr = '0; m_isr = '0; m_tpr = '0; m_dep = 0; m_err = 0;
    for (int i = 0; i < 16; i++) m_stk[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, read through R10 select encoding
    for (int w = 0; w < 8; w++) begin
      expect_rd("R1 R10 request word", w, 32'h0);
      expect_rd("R1 R10 service word", 8 + w, 32'h0);
    end
    expect_rd("R1 task priority", 16, 32'h0);
    expect_rd("R1 processor priority", 24, 32'h0);
    chk("R1 pend_valid", 32'(pend_valid), 32'h0);
    chk("R1 proto_err", 32'(proto_err), 32'h0);

    // R2 reserved vector is stored but never offered
    cycle(1, 8'd5, 0, 0, 0, 0);
    expect_rd("R2 reserved stored", 0, 32'h20);
    chk("R2 reserved not offered", 32'(pend_valid), 32'h0);

    // R2 duplicate request has no further effect
    cycle(1, 8'h41, 0, 0, 0, 0);
    cycle(1, 8'h41, 0, 0, 0, 0);
    expect_rd("R2 duplicate", 2, 32'h2);
    chk("R3 offered", 32'(pend_vector), 32'h41);

    // R6 upper bits dropped; R5 ppr follows tpr; R3 class gate
    cycle(0, 0, 0, 0, 1, 32'hABCD_0050);
    expect_rd("R6 low byte kept", 16, 32'h50);
    expect_rd("R5 ppr from tpr", 24, 32'h50);
    chk("R3 blocked by tpr", 32'(pend_valid), 32'h0);
    cycle(0, 0, 0, 0, 1, 32'h30);
    chk("R3 unblocked", 32'(pend_valid), 32'h1);

    // R4 accept moves vector into service
    cycle(0, 0, 1, 0, 0, 0);
    expect_rd("R4 service bit", 10, 32'h2);
    expect_rd("R4 request cleared", 2, 32'h0);
    expect_rd("R5 ppr from stack", 24, 32'h40);
    // R4 accept with nothing offered is ignored
    cycle(0, 0, 1, 0, 0, 0);
    expect_rd("R4 idle accept", 10, 32'h2);

    // R3 same class is not offered; R9 nesting
    cycle(1, 8'h45, 0, 0, 0, 0);
    chk("R3 equal class held", 32'(pend_valid), 32'h0);
    cycle(1, 8'h9C, 0, 0, 0, 0);
    chk("R3 higher offered", 32'(pend_vector), 32'h9C);
    cycle(0, 0, 1, 0, 0, 0);
    expect_rd("R9 nested ppr", 24, 32'h90);
    expect_rd("R9 nested service", 12, 32'h1000_0000);

    // R11 eoi beats accept in the same cycle
    cycle(1, 8'hE0, 0, 0, 0, 0);
    cycle(0, 0, 1, 1, 0, 0);
    expect_rd("R11 popped service", 12, 32'h0);
    expect_rd("R11 accept ignored", 7, 32'h1);
    expect_rd("R11 ppr", 24, 32'h40);

    // R7 retire in order
    cycle(0, 0, 1, 0, 0, 0);
    cycle(0, 0, 0, 1, 0, 0);
    expect_rd("R7 top retired", 15, 32'h0);
    expect_rd("R7 ppr back", 24, 32'h40);
    cycle(0, 0, 0, 1, 0, 0);
    expect_rd("R7 last retired", 10, 32'h0);
    expect_rd("R7 ppr to tpr", 24, 32'h30);

    // R8 eoi with empty stack
    cycle(0, 0, 0, 1, 0, 0);
    chk("R8 error flagged", 32'(proto_err), 32'h1);
    cycle(0, 0, 0, 0, 0, 0);
    chk("R8 error one cycle", 32'(proto_err), 32'h0);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      cycle(($urandom_range(0, 99) < 50), 8'($urandom_range(0, 255)),
            ($urandom_range(0, 99) < 30), ($urandom_range(0, 99) < 18),
            ($urandom_range(0, 99) < 5), $urandom());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule